// File: doc/BRIEF.md
# Keyboard Controller Command Processor

This block is the host-facing command and data port logic of a PC-style keyboard controller. Software sees two byte locations on a register bus: a data location and a command/status location. Bytes written to the command location are decoded as controller commands. Some commands act at once: they change the mode byte, move the A20 gate, request a system reset or produce a reply byte. Others arm a pending operation that the next write to the data location completes. A read of the command location returns the status byte.

Reply bytes leave on a valid/ready stream toward the keyboard-side output queue, tagged as keyboard or auxiliary data. Bytes for the attached devices leave on a second valid/ready stream, tagged keyboard or mouse. Each stream has a one-entry holding slot. Once valid is high, the data and the tag stay unchanged until the consumer raises ready. Any bus write that would need a slot that is still full is discarded whole and changes no state. The mode byte, the A20 gate, the translation enable and a one-cycle reset request are plain outputs. The queue-full flags come back in as plain inputs.

Top module: `kbc_cmd_proc`

## Requirements
- R1: After reset the mode byte is 0x03, the status byte (with both buffer-full inputs low) reads 0x18, A20 is low, translation is off, no reset request is raised and neither stream is valid.
- R2: A read at the command offset (4) returns the status byte, laid out as: bit 0 the keyboard buffer-full input, bit 2 self-test passed, bits 3 and 4 always 1, bit 5 the auxiliary buffer-full input, and bits 1, 6 and 7 zero. A read at the data offset (0) returns 0x00.
- R3: Command 0x20 puts the current mode byte on the reply stream, tagged keyboard (rep_aux=0). It is valid in the cycle after the write.
- R4: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a pending operation, and the next data write completes it. 0x60 loads the mode byte. 0xD1 writes the output port. 0xD2 sends the byte as a keyboard reply. 0xD3 sends it as an auxiliary reply (rep_aux=1). 0xD4 sends it to the mouse (dev_to_mouse=1). The operation is then disarmed.
- R5: A data write with nothing armed goes out on the device stream with dev_to_mouse=0.
- R6: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4.
- R7: Command 0xAA sets status bit 2 and replies 0x55. Commands 0xA9, 0xAB and 0xC0 each reply 0x00.
- R8: Command 0xD0 replies with a byte whose bit 0 is 1, bit 1 is the A20 state, bit 4 is the keyboard buffer-full input and bit 5 is the auxiliary buffer-full input. All other bits are 0.
- R9: An output-port write sets A20 from data bit 1. If data bit 0 is 0, sys_rst_req pulses high for exactly one cycle.
- R10: Command 0xFE gives a one-cycle sys_rst_req pulse. 0xDF drives A20 high and 0xDD drives it low.
- R11: Command 0xFF and every command byte not listed above change neither the mode, the status, A20 nor an armed operation, and send no byte.
- R12: The translation-enable output follows mode bit 6 as loaded through command 0x60.
- R13: A valid stream output holds its data and tag until ready. A bus write that needs a full slot is discarded with no state change.
- R14: Bus writes to any offset other than 0 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset (0 data, 4 command/status) |
| bus_we | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (status at offset 4) |
| kbd_buf_full | input | 1 | Keyboard output queue holds data |
| aux_buf_full | input | 1 | Auxiliary output queue holds data |
| rep_valid | output | 1 | Reply byte valid |
| rep_ready | input | 1 | Reply consumer accepts |
| rep_data | output | 8 | Reply byte |
| rep_aux | output | 1 | Reply goes to the auxiliary queue |
| dev_valid | output | 1 | Device byte valid |
| dev_ready | input | 1 | Device side accepts |
| dev_data | output | 8 | Byte for a device |
| dev_to_mouse | output | 1 | Device byte is for the mouse |
| mode_o | output | 8 | Mode byte |
| a20_o | output | 1 | A20 gate |
| xlate_en | output | 1 | Scan-code translation enable |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench first checks the two-phase path. A command that is not recognised must not disarm a pending operation. A design that clears the pending code on every command write would send the later data byte to the keyboard instead of the reply stream. It also checks that the pending code clears after use, which a design with a sticky pending code would fail by queueing later data as replies. Back-pressure is tested by holding ready low while further reply-producing and forwarding writes arrive. A design that overwrites a full slot, or that disarms a pending operation whose byte was dropped, shows a changed byte or a misrouted byte. The composed replies are checked with both buffer-full inputs and A20 in both states, which exposes swapped bit positions. The reset request is checked for a width of exactly one cycle.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  // Controller command codes (values are behaviour, names are local)
  localparam logic [7:0] C_MODE_RD   = 8'h20;
  localparam logic [7:0] C_MODE_WR   = 8'h60;
  localparam logic [7:0] C_AUX_OFF   = 8'hA7;
  localparam logic [7:0] C_AUX_ON    = 8'hA8;
  localparam logic [7:0] C_AUX_TST   = 8'hA9;
  localparam logic [7:0] C_SELFTST   = 8'hAA;
  localparam logic [7:0] C_KBD_TST   = 8'hAB;
  localparam logic [7:0] C_KBD_OFF   = 8'hAD;
  localparam logic [7:0] C_KBD_ON    = 8'hAE;
  localparam logic [7:0] C_INP_RD    = 8'hC0;
  localparam logic [7:0] C_OUTP_RD   = 8'hD0;
  localparam logic [7:0] C_OUTP_WR   = 8'hD1;
  localparam logic [7:0] C_KOBUF_WR  = 8'hD2;
  localparam logic [7:0] C_AOBUF_WR  = 8'hD3;
  localparam logic [7:0] C_MOUSE_WR  = 8'hD4;
  localparam logic [7:0] C_GATE_OFF  = 8'hDD;
  localparam logic [7:0] C_GATE_ON   = 8'hDF;
  localparam logic [7:0] C_SYS_RST   = 8'hFE;

  localparam int MB_KBD_DIS = 4;
  localparam int MB_AUX_DIS = 5;
  localparam int MB_XLATE   = 6;

  localparam logic [7:0] SELFTEST_OK = 8'h55;

  typedef enum logic [2:0] {
    PEND_NONE, PEND_MODE, PEND_OUTP, PEND_KOBUF, PEND_AOBUF, PEND_MOUSE
  } pend_e;

  typedef enum logic [2:0] {
    RSRC_NONE, RSRC_MODE, RSRC_ZERO, RSRC_SELFTEST, RSRC_OUTIMG
  } rsrc_e;

  typedef struct packed {
    pend_e      arm;
    rsrc_e      reply;
    logic [7:0] mode_set;
    logic [7:0] mode_clr;
    logic       selftest_set;
    logic       gate_wr;
    logic       gate_val;
    logic       rst_fire;
  } cmd_act_t;

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [7:0] cmd,
  output cmd_act_t   act
);

  always_comb begin
    act = '0;
    act.arm   = PEND_NONE;
    act.reply = RSRC_NONE;
    unique case (cmd)
      C_MODE_RD:  act.reply = RSRC_MODE;
      C_MODE_WR:  act.arm   = PEND_MODE;
      C_OUTP_WR:  act.arm   = PEND_OUTP;
      C_KOBUF_WR: act.arm   = PEND_KOBUF;
      C_AOBUF_WR: act.arm   = PEND_AOBUF;
      C_MOUSE_WR: act.arm   = PEND_MOUSE;
      C_AUX_OFF:  act.mode_set[MB_AUX_DIS] = 1'b1;
      C_AUX_ON:   act.mode_clr[MB_AUX_DIS] = 1'b1;
      C_KBD_OFF:  act.mode_set[MB_KBD_DIS] = 1'b1;
      C_KBD_ON:   act.mode_clr[MB_KBD_DIS] = 1'b1;
      C_AUX_TST, C_KBD_TST, C_INP_RD: act.reply = RSRC_ZERO;
      C_SELFTST: begin
        act.reply        = RSRC_SELFTEST;
        act.selftest_set = 1'b1;
      end
      C_OUTP_RD:  act.reply = RSRC_OUTIMG;
      C_GATE_ON: begin
        act.gate_wr  = 1'b1;
        act.gate_val = 1'b1;
      end
      C_GATE_OFF: act.gate_wr = 1'b1;
      C_SYS_RST:  act.rst_fire = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/kbc_stream_slot.sv
module kbc_stream_slot #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         busy,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);

  assign busy = out_valid && !out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= push_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/kbc_outport.sv
module kbc_outport (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_wr,
  input  logic gate_val,
  input  logic rst_fire,
  output logic gate_o,
  output logic rst_pulse
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_o    <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= rst_fire;
      if (gate_wr) gate_o <= gate_val;
    end
  end

endmodule

// File: rtl/kbc_cmd_proc.sv
module kbc_cmd_proc
  import kbc_pkg::*;
#(
  parameter int         ADDR_W    = 3,
  parameter int         DATA_OFF  = 0,
  parameter int         CMD_OFF   = 4,
  parameter logic [7:0] MODE_INIT = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              kbd_buf_full,
  input  logic              aux_buf_full,
  output logic              rep_valid,
  input  logic              rep_ready,
  output logic [7:0]        rep_data,
  output logic              rep_aux,
  output logic              dev_valid,
  input  logic              dev_ready,
  output logic [7:0]        dev_data,
  output logic              dev_to_mouse,
  output logic [7:0]        mode_o,
  output logic              a20_o,
  output logic              xlate_en,
  output logic              sys_rst_req
);

  localparam int NSLOT = 2;
  localparam int SW    = 9;
  localparam int S_REP = 0;
  localparam int S_DEV = 1;

  logic wr_cmd, wr_dat;
  assign wr_cmd = bus_we && (bus_addr == ADDR_W'(CMD_OFF));
  assign wr_dat = bus_we && (bus_addr == ADDR_W'(DATA_OFF));

  cmd_act_t act;
  kbc_cmd_decode u_dec (.cmd(bus_wdata), .act(act));

  logic [7:0] mode_q, mode_d;
  pend_e      pend_q, pend_d;
  logic       stok_q, stok_d;
  logic       gate_wr, gate_val, rst_fire;

  logic [NSLOT-1:0]  s_push, s_busy, s_valid, s_ready;
  logic [SW-1:0]     s_pdata [NSLOT];
  logic [SW-1:0]     s_odata [NSLOT];

  logic [7:0] status_b, outimg, reply_b;
  assign status_b = {2'b00, aux_buf_full, 1'b1, 1'b1, stok_q, 1'b0, kbd_buf_full};
  assign outimg   = {2'b00, aux_buf_full, kbd_buf_full, 2'b00, a20_o, 1'b1};

  always_comb begin
    unique case (act.reply)
      RSRC_MODE:     reply_b = mode_q;
      RSRC_SELFTEST: reply_b = SELFTEST_OK;
      RSRC_OUTIMG:   reply_b = outimg;
      default:       reply_b = 8'h00;
    endcase
  end

  always_comb begin
    mode_d   = mode_q;
    pend_d   = pend_q;
    stok_d   = stok_q;
    gate_wr  = 1'b0;
    gate_val = 1'b0;
    rst_fire = 1'b0;
    s_push   = '0;
    s_pdata[S_REP] = {1'b0, bus_wdata};
    s_pdata[S_DEV] = {1'b0, bus_wdata};
    if (wr_cmd && (act.reply == RSRC_NONE || !s_busy[S_REP])) begin
      mode_d   = (mode_q | act.mode_set) & ~act.mode_clr;
      stok_d   = stok_q | act.selftest_set;
      gate_wr  = act.gate_wr;
      gate_val = act.gate_val;
      rst_fire = act.rst_fire;
      if (act.arm != PEND_NONE) pend_d = act.arm;
      if (act.reply != RSRC_NONE) begin
        s_push[S_REP]  = 1'b1;
        s_pdata[S_REP] = {1'b0, reply_b};
      end
    end else if (wr_dat) begin
      unique case (pend_q)
        PEND_NONE: if (!s_busy[S_DEV]) begin
          s_push[S_DEV] = 1'b1;
          pend_d        = PEND_NONE;
        end
        PEND_MODE: begin
          mode_d = bus_wdata;
          pend_d = PEND_NONE;
        end
        PEND_OUTP: begin
          gate_wr  = 1'b1;
          gate_val = bus_wdata[1];
          rst_fire = !bus_wdata[0];
          pend_d   = PEND_NONE;
        end
        PEND_KOBUF, PEND_AOBUF: if (!s_busy[S_REP]) begin
          s_push[S_REP]  = 1'b1;
          s_pdata[S_REP] = {pend_q == PEND_AOBUF, bus_wdata};
          pend_d         = PEND_NONE;
        end
        PEND_MOUSE: if (!s_busy[S_DEV]) begin
          s_push[S_DEV]  = 1'b1;
          s_pdata[S_DEV] = {1'b1, bus_wdata};
          pend_d         = PEND_NONE;
        end
        default: pend_d = PEND_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_INIT;
      pend_q <= PEND_NONE;
      stok_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
      stok_q <= stok_d;
    end
  end

  assign s_ready[S_REP] = rep_ready;
  assign s_ready[S_DEV] = dev_ready;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    kbc_stream_slot #(.W(SW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (s_push[g]),
      .push_data (s_pdata[g]),
      .busy      (s_busy[g]),
      .out_valid (s_valid[g]),
      .out_data  (s_odata[g]),
      .out_ready (s_ready[g])
    );
  end

  kbc_outport u_outp (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_wr   (gate_wr),
    .gate_val  (gate_val),
    .rst_fire  (rst_fire),
    .gate_o    (a20_o),
    .rst_pulse (sys_rst_req)
  );

  assign rep_valid    = s_valid[S_REP];
  assign rep_data     = s_odata[S_REP][7:0];
  assign rep_aux      = s_odata[S_REP][8];
  assign dev_valid    = s_valid[S_DEV];
  assign dev_data     = s_odata[S_DEV][7:0];
  assign dev_to_mouse = s_odata[S_DEV][8];
  assign mode_o       = mode_q;
  assign xlate_en     = mode_q[MB_XLATE];
  assign bus_rdata    = (bus_addr == ADDR_W'(CMD_OFF)) ? status_b : 8'h00;

endmodule

// File: rtl/kbc_cmd_proc_chk.sv
module kbc_cmd_proc_chk #(
  parameter int ADDR_W  = 3,
  parameter int CMD_OFF = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_wdata,
  input logic              rep_valid,
  input logic              rep_ready,
  input logic [7:0]        rep_data,
  input logic              rep_aux,
  input logic              dev_valid,
  input logic              dev_ready,
  input logic [7:0]        dev_data,
  input logic              dev_to_mouse,
  input logic [7:0]        mode_o,
  input logic              a20_o,
  input logic              sys_rst_req
);

  logic cw;
  assign cw = bus_we && (bus_addr == ADDR_W'(CMD_OFF));

  a_r13_rep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid && !rep_ready |=> rep_valid && $stable(rep_data) && $stable(rep_aux));

  a_r13_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid && !dev_ready |=> dev_valid && $stable(dev_data) && $stable(dev_to_mouse));

  a_r9_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);

  a_r10_gate_on: assert property (@(posedge clk) disable iff (!rst_n)
    cw && bus_wdata == 8'hDF |=> a20_o);

  a_r10_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    cw && bus_wdata == 8'hDD |=> !a20_o);

  a_r10_rst_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cw && bus_wdata == 8'hFE |=> sys_rst_req);

  a_r6_aux_dis: assert property (@(posedge clk) disable iff (!rst_n)
    cw && bus_wdata == 8'hA7 |=> mode_o[5]);

  a_r6_kbd_en: assert property (@(posedge clk) disable iff (!rst_n)
    cw && bus_wdata == 8'hAE |=> !mode_o[4]);

  a_r3_mode_reply: assert property (@(posedge clk) disable iff (!rst_n)
    cw && bus_wdata == 8'h20 && !(rep_valid && !rep_ready)
    |=> rep_valid && !rep_aux && rep_data == $past(mode_o));

endmodule

bind kbc_cmd_proc kbc_cmd_proc_chk #(.ADDR_W(ADDR_W), .CMD_OFF(CMD_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .rep_valid(rep_valid), .rep_ready(rep_ready),
  .rep_data(rep_data), .rep_aux(rep_aux), .dev_valid(dev_valid),
  .dev_ready(dev_ready), .dev_data(dev_data), .dev_to_mouse(dev_to_mouse),
  .mode_o(mode_o), .a20_o(a20_o), .sys_rst_req(sys_rst_req)
);

// File: tb/kbc_cmd_proc_bench.sv
module kbc_cmd_proc_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       kbd_buf_full = 1'b0, aux_buf_full = 1'b0;
  logic       rep_valid, rep_ready = 1'b1, rep_aux;
  logic [7:0] rep_data;
  logic       dev_valid, dev_ready = 1'b1, dev_to_mouse;
  logic [7:0] dev_data, mode_o;
  logic       a20_o, xlate_en, sys_rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  kbc_cmd_proc u_kbc_cmd_proc (.*);

  // vector: [36:33] req, [32] cmd, [31:24] byte, [23:22] kind 0 none 1 rep 2 dev,
  //         [21] aux/mouse tag, [20:13] out byte, [12:5] mode, [4] a20
  function automatic logic [36:0] v(input logic [3:0] r, input bit c, input logic [7:0] d,
                                    input logic [1:0] k, input bit s, input logic [7:0] ed,
                                    input logic [7:0] em, input bit ea);
    return {r, c, d, k, s, ed, em, ea, 4'h0};
  endfunction

  localparam int NV = 27;
  localparam logic [36:0] VEC [NV] = '{
    v(3,  1, 8'h20, 1, 0, 8'h03, 8'h03, 0), // R3
    v(6,  1, 8'hA7, 0, 0, 8'h00, 8'h23, 0), // R6
    v(6,  1, 8'hAD, 0, 0, 8'h00, 8'h33, 0),
    v(3,  1, 8'h20, 1, 0, 8'h33, 8'h33, 0),
    v(6,  1, 8'hA8, 0, 0, 8'h00, 8'h13, 0),
    v(6,  1, 8'hAE, 0, 0, 8'h00, 8'h03, 0),
    v(7,  1, 8'hAA, 1, 0, 8'h55, 8'h03, 0), // R7
    v(7,  1, 8'hA9, 1, 0, 8'h00, 8'h03, 0),
    v(7,  1, 8'hAB, 1, 0, 8'h00, 8'h03, 0),
    v(7,  1, 8'hC0, 1, 0, 8'h00, 8'h03, 0),
    v(10, 1, 8'hDF, 0, 0, 8'h00, 8'h03, 1), // R10
    v(8,  1, 8'hD0, 1, 0, 8'h03, 8'h03, 1), // R8
    v(10, 1, 8'hDD, 0, 0, 8'h00, 8'h03, 0),
    v(8,  1, 8'hD0, 1, 0, 8'h01, 8'h03, 0),
    v(4,  1, 8'h60, 0, 0, 8'h00, 8'h03, 0), // R4
    v(4,  0, 8'h47, 0, 0, 8'h00, 8'h47, 0),
    v(4,  1, 8'hD2, 0, 0, 8'h00, 8'h47, 0),
    v(4,  0, 8'h9C, 1, 0, 8'h9C, 8'h47, 0),
    v(4,  1, 8'hD3, 0, 0, 8'h00, 8'h47, 0),
    v(4,  0, 8'h5A, 1, 1, 8'h5A, 8'h47, 0),
    v(4,  1, 8'hD4, 0, 0, 8'h00, 8'h47, 0),
    v(4,  0, 8'hF4, 2, 1, 8'hF4, 8'h47, 0),
    v(5,  0, 8'hED, 2, 0, 8'hED, 8'h47, 0), // R5
    v(4,  1, 8'h60, 0, 0, 8'h00, 8'h47, 0),
    v(4,  0, 8'h03, 0, 0, 8'h00, 8'h03, 0),
    v(11, 1, 8'hFF, 0, 0, 8'h00, 8'h03, 0), // R11
    v(11, 1, 8'h42, 0, 0, 8'h00, 8'h03, 0)
  };

  task automatic chk(input int r, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual 0x%02h expected 0x%02h", r, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 3'd4;
  endtask

  task automatic status_is(input int r, input logic [7:0] e);
    bus_addr = 3'd4; #1;
    chk(r, "status", bus_rdata, e);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL R1 watchdog: actual 0x01 expected 0x00");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(1, "mode", mode_o, 8'h03);
    status_is(1, 8'h18);
    chk(1, "a20", {7'd0, a20_o}, 8'h00);
    chk(1, "xlate", {7'd0, xlate_en}, 8'h00);
    chk(1, "rstreq", {7'd0, sys_rst_req}, 8'h00);
    chk(1, "valids", {6'd0, rep_valid, dev_valid}, 8'h00);
    // R2 data offset reads zero
    bus_addr = 3'd0; #1; chk(2, "data read", bus_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [36:0] e;
      int r;
      e = VEC[i];
      r = int'(e[36:33]);
      wr(e[32] ? 3'd4 : 3'd0, e[31:24]);
      chk(r, "rep_valid", {7'd0, rep_valid}, {7'd0, e[23:22] == 2'd1});
      chk(r, "dev_valid", {7'd0, dev_valid}, {7'd0, e[23:22] == 2'd2});
      if (e[23:22] == 2'd1) begin
        chk(r, "rep_data", rep_data, e[20:13]);
        chk(r, "rep_aux", {7'd0, rep_aux}, {7'd0, e[21]});
      end
      if (e[23:22] == 2'd2) begin
        chk(r, "dev_data", dev_data, e[20:13]);
        chk(r, "dev_to_mouse", {7'd0, dev_to_mouse}, {7'd0, e[21]});
      end
      chk(r, "mode", mode_o, e[12:5]);
      chk(r, "a20", {7'd0, a20_o}, {7'd0, e[4]});
    end

    // R2 status layout with self-test set and buffer-full inputs
    status_is(2, 8'h1C);
    kbd_buf_full = 1'b1; aux_buf_full = 1'b1;
    status_is(2, 8'h3D);
    // R8 image with both buffer flags
    wr(3'd4, 8'hD0);
    chk(8, "image", rep_data, 8'h31);
    aux_buf_full = 1'b0;
    status_is(2, 8'h1D);
    kbd_buf_full = 1'b0;

    // R9 output port writes
    wr(3'd4, 8'hD1); wr(3'd0, 8'h03);
    chk(9, "a20 set", {7'd0, a20_o}, 8'h01);
    chk(9, "no rst", {7'd0, sys_rst_req}, 8'h00);
    wr(3'd4, 8'hD1); wr(3'd0, 8'h00);
    chk(9, "a20 clr", {7'd0, a20_o}, 8'h00);
    chk(9, "rst pulse", {7'd0, sys_rst_req}, 8'h01);
    @(negedge clk);
    chk(9, "rst end", {7'd0, sys_rst_req}, 8'h00);
    // R10 reset command
    wr(3'd4, 8'hFE);
    chk(10, "rst pulse", {7'd0, sys_rst_req}, 8'h01);
    @(negedge clk);
    chk(10, "rst end", {7'd0, sys_rst_req}, 8'h00);

    // R11 unknown commands keep an armed operation
    wr(3'd4, 8'hD2); wr(3'd4, 8'h42); wr(3'd4, 8'hFF);
    chk(11, "no reply", {7'd0, rep_valid}, 8'h00);
    status_is(11, 8'h1C);
    wr(3'd0, 8'h77);
    chk(11, "armed kept", {6'd0, rep_valid, rep_aux}, 8'h02);
    chk(11, "armed byte", rep_data, 8'h77);

    // R12 translation follows mode bit 6
    wr(3'd4, 8'h60); wr(3'd0, 8'h40);
    chk(12, "xlate on", {7'd0, xlate_en}, 8'h01);
    wr(3'd4, 8'h60); wr(3'd0, 8'h03);
    chk(12, "xlate off", {7'd0, xlate_en}, 8'h00);

    // R13 back-pressure on the reply stream
    rep_ready = 1'b0;
    wr(3'd4, 8'h20);
    repeat (3) @(negedge clk);
    chk(13, "rep held", {7'd0, rep_valid}, 8'h01);
    chk(13, "rep byte", rep_data, 8'h03);
    wr(3'd4, 8'hA7);
    chk(13, "mode while full", mode_o, 8'h23);
    wr(3'd4, 8'h20);
    chk(13, "dropped cmd", rep_data, 8'h03);
    wr(3'd4, 8'hD2); wr(3'd0, 8'h11);
    chk(13, "dropped data", rep_data, 8'h03);
    rep_ready = 1'b1;
    @(negedge clk);
    chk(13, "rep drained", {7'd0, rep_valid}, 8'h00);
    wr(3'd0, 8'h22);
    chk(13, "armed after drop", rep_data, 8'h22);
    wr(3'd4, 8'hA8);
    // R13 back-pressure on the device stream
    dev_ready = 1'b0;
    wr(3'd0, 8'h31);
    wr(3'd4, 8'hD4); wr(3'd0, 8'h32);
    chk(13, "dev held", dev_data, 8'h31);
    chk(13, "dev tag held", {7'd0, dev_to_mouse}, 8'h00);
    dev_ready = 1'b1;
    @(negedge clk);
    wr(3'd0, 8'h33);
    chk(13, "dev after drop", {dev_to_mouse, dev_data[6:0]}, 8'hB3);

    // R14 stray offsets
    @(negedge clk);
    wr(3'd2, 8'hAD);
    chk(14, "mode", mode_o, 8'h03);
    wr(3'd1, 8'h55);
    chk(14, "no output", {6'd0, rep_valid, dev_valid}, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule